// File: doc/BRIEF.md
# Pattern RAM with mono expansion

This block holds the 8x8 pixel brush pattern that a 2D blitter tiles across its destination. It has 256 bytes of byte-addressed storage. The pixel depth is 8, 16 or 32 bits, chosen by a depth input. At that depth the pattern takes up 64, 128 or 256 bytes. A host register bus can fill the storage in two ways. Direct-colour writes put raw bytes, halfwords or words at a byte offset. Mono writes take one bit per pixel and expand each bit into a whole pixel, using either a foreground or a background colour register.

One mono byte describes a full scanline of eight pixels, and it is expanded in a single clock. A two-byte or four-byte mono write expands that many consecutive scanlines in the same clock. The mono write offset picks where in storage the expanded scanline lands. The raster pipeline reads one pixel per clock by giving its (x, y) pattern coordinate. The result appears one clock later, zero-extended to 32 bits.

Top module: `pat_ram_mono`

## Requirements
- R1: While reset is asserted, `rd_pix_o` is zero. The foreground and background colour registers reset to zero, so a mono write made after reset stores zero pixels.
- R2: Depth code 0 gives B=1 byte per pixel, code 1 gives B=2, and codes 2 and 3 both give B=4. Pixel (x, y) occupies B bytes starting at byte offset y*8*B + x*B.
- R3: A direct write stores byte k of `dir_wdata_i` (bits 8k+7..8k) at offset (`dir_addr_i` + k) mod 256. This happens for k below the lane count. Size code 0 gives 1 lane, code 1 gives 2 lanes, and codes 2 and 3 give 4 lanes.
- R4: Pixels are little-endian. The byte at the lowest offset is bits 7..0 of the pixel. At 32 bits per pixel the bytes hold, in order, blue, green, red and alpha.
- R5: `rd_pix_o` gives the pixel at (`rd_x_i`, `rd_y_i`) one clock after the coordinate is presented. It is read with the depth present at that time, and bits above 8*B are zero.
- R6: A colour register write takes effect from the next clock on. A mono write in the same clock as a colour register write expands with the colour value held before that write.
- R7: Each mono bit fills its pixel with the foreground colour when the bit is 1 and the background colour when it is 0. Byte b of the pixel gets colour bits 8b+7..8b. Bit 7 of a mono byte is pixel x=0 and bit 0 is x=7.
- R8: Mono byte k of a write lands on the scanline whose storage starts at ((`mono_addr_i` + k) * 8 * B) mod 256. Only those 8*B bytes are written.
- R9: A mono write with size code 1 expands 2 scanlines in one clock, and size code 2 or 3 expands 4 scanlines in one clock. Lane k of `mono_wdata_i` supplies scanline k.
- R10: When a mono write and a direct write arrive in the same clock, only the mono write is applied. The direct write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| depth_i | input | 2 | Pixel depth code (0: 8, 1: 16, 2/3: 32 bits) |
| clr_fg_we_i | input | 1 | Load the foreground colour register |
| clr_bg_we_i | input | 1 | Load the background colour register |
| clr_wdata_i | input | 32 | Colour register write data |
| dir_we_i | input | 1 | Direct-colour write strobe |
| dir_addr_i | input | 8 | Direct-colour byte offset |
| dir_size_i | input | 2 | Direct write size (0: byte, 1: halfword, 2/3: word) |
| dir_wdata_i | input | 32 | Direct write data, lane 0 in bits 7..0 |
| mono_we_i | input | 1 | Mono write strobe |
| mono_addr_i | input | 8 | Mono window offset of lane 0 |
| mono_size_i | input | 2 | Mono write size (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| mono_wdata_i | input | 32 | Mono bits, lane k in bits 8k+7..8k |
| rd_x_i | input | 3 | Pattern x coordinate of the read |
| rd_y_i | input | 3 | Pattern y coordinate of the read |
| rd_pix_o | output | 32 | Pixel read one clock after the request |

## Verification
The bench builds the block with its default parameters: a 256-byte store and a side of 8 pixels. With these values all three depths can be reached, and a 32-bit direct write at offset 0xFE wraps around to offset 0. A mono offset past the 64-byte pattern at 8 bits per pixel writes into bytes that a 32-bit read can see. Same-clock collisions are driven on purpose: colour update against mono write, and mono write against direct write.

// File: rtl/pat_pkg.sv
package pat_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    PIX_8  = 2'd0,
    PIX_16 = 2'd1,
    PIX_32 = 2'd2
  } pix_depth_e;

  // log2 of bytes per pixel; code 3 behaves as 32 bits per pixel
  function automatic int unsigned depth_shift(input logic [1:0] code);
    case (code)
      PIX_8:   return 0;
      PIX_16:  return 1;
      default: return 2;
    endcase
  endfunction

  // number of byte lanes carried by a write of the given size code
  function automatic int unsigned xfer_lanes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/pat_color_regs.sv
module pat_color_regs
  import pat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fg_we_i,
  input  logic              bg_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] fg_o,
  output logic [WORD_W-1:0] bg_o
);

  logic [WORD_W-1:0] fg_q, fg_d, bg_q, bg_d;
  logic              fg_en, bg_en;

  always_comb begin
    fg_en = fg_we_i;
    bg_en = bg_we_i;
    fg_d  = wdata_i;
    bg_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fg_q <= '0;
      bg_q <= '0;
    end else begin
      if (fg_en) fg_q <= fg_d;
      if (bg_en) bg_q <= bg_d;
    end
  end

  assign fg_o = fg_q;
  assign bg_o = bg_q;

  // R6: a loaded value is visible the next clock, otherwise held
  a_r6_fg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fg_we_i |=> fg_o == $past(wdata_i));
  a_r6_bg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_we_i |=> bg_o == $past(wdata_i));
  a_r6_fg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fg_we_i |=> $stable(fg_o));
  a_r6_bg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bg_we_i |=> $stable(bg_o));

endmodule

// File: rtl/pat_wr_expand.sv
module pat_wr_expand
  import pat_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 256,
  parameter int unsigned SIDE      = 8,
  localparam int unsigned AW       = $clog2(MEM_BYTES),
  localparam int unsigned LANES    = WORD_W / LANE_W
) (
  input  logic [1:0]           depth_i,
  input  logic                 dir_we_i,
  input  logic [AW-1:0]        dir_addr_i,
  input  logic [1:0]           dir_size_i,
  input  logic [WORD_W-1:0]    dir_wdata_i,
  input  logic                 mono_we_i,
  input  logic [AW-1:0]        mono_addr_i,
  input  logic [1:0]           mono_size_i,
  input  logic [WORD_W-1:0]    mono_wdata_i,
  input  logic [WORD_W-1:0]    fg_i,
  input  logic [WORD_W-1:0]    bg_i,
  output logic [MEM_BYTES-1:0] byte_we_o,
  output logic [7:0]           byte_wd_o [MEM_BYTES]
);

  always_comb begin
    int unsigned       bpp;
    int unsigned       stride;
    int unsigned       idx;
    logic [WORD_W-1:0] col;
    bpp       = 1 << depth_shift(depth_i);
    stride    = SIDE * bpp;
    byte_we_o = '0;
    idx       = 0;
    col       = '0;
    for (int i = 0; i < MEM_BYTES; i++) byte_wd_o[i] = '0;
    if (mono_we_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < xfer_lanes(mono_size_i)) begin
          for (int p = 0; p < SIDE; p++) begin
            col = mono_wdata_i[k*SIDE + SIDE-1-p] ? fg_i : bg_i;
            for (int b = 0; b < LANES; b++) begin
              if (b < bpp) begin
                idx = ((32'(mono_addr_i) + k) * stride + p * bpp + b) % MEM_BYTES;
                byte_we_o[idx] = 1'b1;
                byte_wd_o[idx] = col[b*LANE_W +: LANE_W];
              end
            end
          end
        end
      end
    end else if (dir_we_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < xfer_lanes(dir_size_i)) begin
          idx = (32'(dir_addr_i) + k) % MEM_BYTES;
          byte_we_o[idx] = 1'b1;
          byte_wd_o[idx] = dir_wdata_i[k*LANE_W +: LANE_W];
        end
      end
    end
  end

endmodule

// File: rtl/pat_store.sv
module pat_store
  import pat_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 256,
  parameter int unsigned SIDE      = 8,
  localparam int unsigned XW       = $clog2(SIDE),
  localparam int unsigned LANES    = WORD_W / LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MEM_BYTES-1:0] byte_we_i,
  input  logic [7:0]           byte_wd_i [MEM_BYTES],
  input  logic [1:0]           depth_i,
  input  logic [XW-1:0]        rd_x_i,
  input  logic [XW-1:0]        rd_y_i,
  output logic [WORD_W-1:0]    rd_pix_o
);

  logic [7:0]        mem_q [MEM_BYTES];
  logic [WORD_W-1:0] rd_d, rd_q;

  // storage: no reset, per-byte clock enable
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < MEM_BYTES; i++) begin
      if (byte_we_i[i]) mem_q[i] <= byte_wd_i[i];
    end
  end

  always_comb begin
    int unsigned bpp;
    int unsigned base;
    bpp  = 1 << depth_shift(depth_i);
    base = 32'(rd_y_i) * SIDE * bpp + 32'(rd_x_i) * bpp;
    rd_d = '0;
    for (int b = 0; b < LANES; b++) begin
      if (b < bpp) rd_d[b*LANE_W +: LANE_W] = mem_q[(base + b) % MEM_BYTES];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_pix_o = rd_q;

  // R5: upper bits of a narrow pixel come back as zero
  a_r5_zext8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(depth_i) == 2'd0 |-> rd_pix_o[WORD_W-1:8] == '0);
  a_r5_zext16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(depth_i) == 2'd1 |-> rd_pix_o[WORD_W-1:16] == '0);

endmodule

// File: rtl/pat_ram_mono.sv
module pat_ram_mono
  import pat_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 256,
  parameter int unsigned SIDE      = 8,
  localparam int unsigned AW       = $clog2(MEM_BYTES),
  localparam int unsigned XW       = $clog2(SIDE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        depth_i,
  input  logic              clr_fg_we_i,
  input  logic              clr_bg_we_i,
  input  logic [WORD_W-1:0] clr_wdata_i,
  input  logic              dir_we_i,
  input  logic [AW-1:0]     dir_addr_i,
  input  logic [1:0]        dir_size_i,
  input  logic [WORD_W-1:0] dir_wdata_i,
  input  logic              mono_we_i,
  input  logic [AW-1:0]     mono_addr_i,
  input  logic [1:0]        mono_size_i,
  input  logic [WORD_W-1:0] mono_wdata_i,
  input  logic [XW-1:0]     rd_x_i,
  input  logic [XW-1:0]     rd_y_i,
  output logic [WORD_W-1:0] rd_pix_o
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [WORD_W-1:0]    fg, bg;
  logic [MEM_BYTES-1:0] byte_we;
  logic [7:0]           byte_wd [MEM_BYTES];

  pat_color_regs u_colors (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .fg_we_i (clr_fg_we_i),
    .bg_we_i (clr_bg_we_i),
    .wdata_i (clr_wdata_i),
    .fg_o    (fg),
    .bg_o    (bg)
  );

  pat_wr_expand #(.MEM_BYTES(MEM_BYTES), .SIDE(SIDE)) u_expand (
    .depth_i      (depth_i),
    .dir_we_i     (dir_we_i),
    .dir_addr_i   (dir_addr_i),
    .dir_size_i   (dir_size_i),
    .dir_wdata_i  (dir_wdata_i),
    .mono_we_i    (mono_we_i),
    .mono_addr_i  (mono_addr_i),
    .mono_size_i  (mono_size_i),
    .mono_wdata_i (mono_wdata_i),
    .fg_i         (fg),
    .bg_i         (bg),
    .byte_we_o    (byte_we),
    .byte_wd_o    (byte_wd)
  );

  pat_store #(.MEM_BYTES(MEM_BYTES), .SIDE(SIDE)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .byte_we_i (byte_we),
    .byte_wd_i (byte_wd),
    .depth_i   (depth_i),
    .rd_x_i    (rd_x_i),
    .rd_y_i    (rd_y_i),
    .rd_pix_o  (rd_pix_o)
  );

  // expected write footprints, from the port-level request
  int unsigned mono_span, dir_span;
  always_comb begin
    mono_span = xfer_lanes(mono_size_i) * SIDE * (1 << depth_shift(depth_i));
    dir_span  = xfer_lanes(dir_size_i);
  end

  // R9 / R8: a mono write touches exactly lanes*8*B distinct bytes
  a_r9_mono_span: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    mono_we_i |-> $countones(byte_we) == mono_span);
  // R3: a lone direct write touches exactly its lane count
  a_r3_dir_span: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (dir_we_i && !mono_we_i) |-> $countones(byte_we) == dir_span);
  // R10: direct data never reaches storage during a mono write
  a_r10_mono_wins: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (dir_we_i && mono_we_i) |-> $countones(byte_we) == mono_span);
  // R3: no strobe, no store
  a_r3_idle: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!dir_we_i && !mono_we_i) |-> byte_we == '0);

endmodule

// File: tb/pat_ram_mono_bench.sv
module pat_ram_mono_bench;

  logic        clk;
  logic        rst_n;
  logic [1:0]  depth;
  logic        fg_we, bg_we;
  logic [31:0] cwdata;
  logic        dwe;
  logic [7:0]  daddr;
  logic [1:0]  dsize;
  logic [31:0] dwdata;
  logic        mwe;
  logic [7:0]  maddr;
  logic [1:0]  msize;
  logic [31:0] mwdata;
  logic [2:0]  rx, ry;
  logic [31:0] pix;

  int n_chk  = 0;
  int n_fail = 0;

  pat_ram_mono u_pat_ram_mono (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .depth_i      (depth),
    .clr_fg_we_i  (fg_we),
    .clr_bg_we_i  (bg_we),
    .clr_wdata_i  (cwdata),
    .dir_we_i     (dwe),
    .dir_addr_i   (daddr),
    .dir_size_i   (dsize),
    .dir_wdata_i  (dwdata),
    .mono_we_i    (mwe),
    .mono_addr_i  (maddr),
    .mono_size_i  (msize),
    .mono_wdata_i (mwdata),
    .rd_x_i       (rx),
    .rd_y_i       (ry),
    .rd_pix_o     (pix)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [2:0] WD = 3'd0, WM = 3'd1, FG = 3'd2, BG = 3'd3, RD = 3'd4;
  localparam int N = 34;
  // {op, depth, addr or {y,x}, size, data, expected, requirement}
  localparam logic [82:0] TBL [N] = '{
    {FG, 2'd2, 8'h00, 2'd2, 32'h11223344, 32'h0,        4'd6},  // R6
    {BG, 2'd2, 8'h00, 2'd2, 32'hAABBCCDD, 32'h0,        4'd6},  // R6
    {WM, 2'd2, 8'h00, 2'd0, 32'h00000081, 32'h0,        4'd7},  // R7
    {RD, 2'd2, 8'h00, 2'd0, 32'h0,        32'h11223344, 4'd7},
    {RD, 2'd2, 8'h01, 2'd0, 32'h0,        32'hAABBCCDD, 4'd7},
    {RD, 2'd2, 8'h07, 2'd0, 32'h0,        32'h11223344, 4'd7},
    {WM, 2'd2, 8'h01, 2'd2, 32'h0FF000FF, 32'h0,        4'd9},  // R9
    {RD, 2'd2, 8'h0D, 2'd0, 32'h0,        32'h11223344, 4'd9},
    {RD, 2'd2, 8'h15, 2'd0, 32'h0,        32'hAABBCCDD, 4'd9},
    {RD, 2'd2, 8'h1B, 2'd0, 32'h0,        32'h11223344, 4'd9},
    {RD, 2'd2, 8'h1C, 2'd0, 32'h0,        32'hAABBCCDD, 4'd9},
    {RD, 2'd2, 8'h24, 2'd0, 32'h0,        32'h11223344, 4'd9},
    {WD, 2'd2, 8'h20, 2'd2, 32'hCAFEBABE, 32'h0,        4'd3},  // R3
    {RD, 2'd2, 8'h08, 2'd0, 32'h0,        32'hCAFEBABE, 4'd4},  // R4
    {WD, 2'd2, 8'h21, 2'd0, 32'h00000055, 32'h0,        4'd3},
    {RD, 2'd2, 8'h08, 2'd0, 32'h0,        32'hCAFE55BE, 4'd3},
    {WD, 2'd2, 8'h24, 2'd1, 32'h00001234, 32'h0,        4'd3},
    {RD, 2'd2, 8'h09, 2'd0, 32'h0,        32'h11221234, 4'd3},
    {RD, 2'd3, 8'h08, 2'd0, 32'h0,        32'hCAFE55BE, 4'd2},  // R2
    {RD, 2'd0, 8'h00, 2'd0, 32'h0,        32'h00000044, 4'd5},  // R5
    {RD, 2'd0, 8'h04, 2'd0, 32'h0,        32'h000000DD, 4'd2},
    {RD, 2'd0, 8'h20, 2'd0, 32'h0,        32'h000000BE, 4'd2},
    {RD, 2'd1, 8'h10, 2'd0, 32'h0,        32'h000055BE, 4'd2},
    {WM, 2'd0, 8'h08, 2'd0, 32'h000000A5, 32'h0,        4'd8},  // R8
    {RD, 2'd2, 8'h10, 2'd0, 32'h0,        32'hDD44DD44, 4'd8},
    {RD, 2'd2, 8'h11, 2'd0, 32'h0,        32'h44DD44DD, 4'd8},
    {RD, 2'd2, 8'h12, 2'd0, 32'h0,        32'hAABBCCDD, 4'd8},
    {WM, 2'd1, 8'h00, 2'd0, 32'h00000080, 32'h0,        4'd7},
    {RD, 2'd1, 8'h00, 2'd0, 32'h0,        32'h00003344, 4'd7},
    {RD, 2'd1, 8'h01, 2'd0, 32'h0,        32'h0000CCDD, 4'd7},
    {WD, 2'd2, 8'hFC, 2'd2, 32'h00000000, 32'h0,        4'd3},
    {WD, 2'd2, 8'hFE, 2'd3, 32'h04030201, 32'h0,        4'd3},  // wraps
    {RD, 2'd2, 8'h3F, 2'd0, 32'h0,        32'h02010000, 4'd3},
    {RD, 2'd2, 8'h00, 2'd0, 32'h0,        32'hCCDD0403, 4'd3}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic idle();
    fg_we = 0; bg_we = 0; dwe = 0; mwe = 0;
  endtask

  task automatic step(input logic [2:0] op, input logic [1:0] dep, input logic [7:0] a,
                      input logic [1:0] sz, input logic [31:0] dat,
                      input logic [31:0] exp, input int req);
    @(negedge clk);
    depth = dep;
    case (op)
      WD: begin dwe = 1; daddr = a; dsize = sz; dwdata = dat; end
      WM: begin mwe = 1; maddr = a; msize = sz; mwdata = dat; end
      FG: begin fg_we = 1; cwdata = dat; end
      BG: begin bg_we = 1; cwdata = dat; end
      default: begin rx = a[2:0]; ry = a[5:3]; end
    endcase
    @(negedge clk);
    idle();
    if (op == RD) check(req, pix, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; depth = 2'd2; idle();
    cwdata = '0; daddr = '0; dsize = '0; dwdata = '0;
    maddr = '0; msize = '0; mwdata = '0; rx = '0; ry = '0;
    repeat (3) @(negedge clk);
    check(1, pix, 32'h0);  // R1: output cleared in reset
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: colour registers come out of reset at zero
    step(WM, 2'd2, 8'h00, 2'd2, 32'hFFFFFFFF, 32'h0, 1);
    step(RD, 2'd2, 8'h1A, 2'd0, 32'h0, 32'h0, 1);

    for (int i = 0; i < N; i++)
      step(TBL[i][82:80], TBL[i][79:78], TBL[i][77:70], TBL[i][69:68],
           TBL[i][67:36], TBL[i][35:4], int'(TBL[i][3:0]));

    // R10: mono and direct in the same clock, direct aimed elsewhere
    @(negedge clk);
    depth = 2'd2;
    mwe = 1; maddr = 8'h05; msize = 2'd0; mwdata = 32'h0;
    dwe = 1; daddr = 8'hFC; dsize = 2'd2; dwdata = 32'h12345678;
    @(negedge clk);
    idle();
    step(RD, 2'd2, 8'h3F, 2'd0, 32'h0, 32'h02010000, 10);
    step(RD, 2'd2, 8'h2D, 2'd0, 32'h0, 32'hAABBCCDD, 10);

    // R6: colour write and mono write in the same clock
    @(negedge clk);
    depth = 2'd2;
    fg_we = 1; cwdata = 32'h99999999;
    mwe = 1; maddr = 8'h00; msize = 2'd0; mwdata = 32'h000000FF;
    @(negedge clk);
    idle();
    step(RD, 2'd2, 8'h00, 2'd0, 32'h0, 32'h11223344, 6);
    step(WM, 2'd2, 8'h00, 2'd0, 32'h000000FF, 32'h0, 6);
    step(RD, 2'd2, 8'h03, 2'd0, 32'h0, 32'h99999999, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule